// File: doc/BRIEF.md
# Dual-Width ROM Read Port

This block is a synthesizable read port for a fixed-content memory. The port can present its contents as 16-bit words or as 8-bit bytes. A 20-bit word address selects a 16-bit entry. In byte mode, one more address bit of lower weight picks which half of that entry is returned. Two active-low controls gate the bus. Chip select decides between standby and active operation, and output gate decides whether an active port drives data. A separate identification input replaces array data with two fixed identification codes.

The model uses no tri-state nets. It drives a 16-bit data vector and a 16-bit lane-enable vector. A lane whose enable bit is 0 is treated as high impedance and always carries 0. Every output is registered, so a read returns its data on the clock edge after the inputs are sampled. The contents are a fixed function of the address and a seed parameter. This lets any depth be modelled without storage. A low-power flag shows when the port is in standby.

Top module: `dual_rom_port`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `wide`=1 and `id_mode`=0, the registered output is `dout`=W(addr) with `dout_en`=16'hFFFF. Here W(a) = (a[15:0]*16'h9E37 mod 2^16) XOR {a[19:16] repeated four times} XOR SEED, and SEED defaults to 16'h5A3C.
- R2: In byte mode (`wide`=0, active, `id_mode`=0), `a_m1`=0 returns W(addr)[7:0] on `dout[7:0]`.
- R3: In byte mode, `a_m1`=1 returns W(addr)[15:8], also on `dout[7:0]`.
- R4: In any active byte-mode read, `dout_en`=16'h00FF and `dout[15:8]`=0.
- R5: With `ce_n`=0 and `oe_n`=1 (output off), `dout_en`=0, `dout`=0 and `low_power`=0.
- R6: With `ce_n`=1 (standby), `dout_en`=0, `dout`=0 and `low_power`=1, whatever the levels of `oe_n`, `wide` and `id_mode`.
- R7: In an active read with `id_mode`=1, `addr[0]`=0 returns 8'h20 and `addr[0]`=1 returns 8'hB1. The other address bits and `a_m1` are ignored. In word mode the code appears in both bytes with `dout_en`=16'hFFFF. In byte mode it appears in `dout[7:0]` only, with `dout_en`=16'h00FF.
- R8: Outputs change only on the clock edge after inputs are sampled. Input changes between edges do not affect them.
- R9: While `rst` is high, and in the first cycle after it is released, `dout`=0, `dout_en`=0 and `low_power`=1.
- R10: Any `dout` bit whose `dout_en` bit is 0 reads 0.
- R11: In word mode, `a_m1` has no effect on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 20 | Word address |
| a_m1 | input | 1 | Half-select address bit, used in byte mode only |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| wide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| id_mode | input | 1 | Selects identification-code readout |
| dout | output | 16 | Registered data bus |
| dout_en | output | 16 | Per-lane drive enable; 0 means high impedance |
| low_power | output | 1 | High while the port is in standby |

## Verification
The array read path is checked on a sweep of addresses that stride across the whole 20-bit space. The sweep includes the all-zero and all-one addresses. Each address is read as a word, as a low byte and as a high byte, so a swapped half-select or a dropped upper address bit shows up as a mismatch. Word reads with `a_m1` toggled separate a stray half-select in word mode from correct behaviour. Identification reads with varied upper address bits separate code selection on bit 0 from dependence on other bits. Standby and output-off are tried with every combination of the other controls, and a mid-cycle input change exposes any combinational path to the outputs.

// File: rtl/rom_port_pkg.sv
package rom_port_pkg;

    localparam int BYTE_W     = 8;
    localparam int DATA_W     = 16;
    localparam int LANES      = DATA_W / BYTE_W;
    localparam logic [BYTE_W-1:0] ID_MAKER  = 8'h20;
    localparam logic [BYTE_W-1:0] ID_DEVICE = 8'hB1;
    localparam logic [DATA_W-1:0] MIX_K     = 16'h9E37;

    typedef enum logic [2:0] {
        PM_STANDBY,
        PM_OUT_OFF,
        PM_WORD,
        PM_BYTE,
        PM_ID_WORD,
        PM_ID_BYTE
    } port_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] en;
        logic              lp;
    } bus_t;

    function automatic logic [BYTE_W-1:0] id_code(input logic sel);
        return sel ? ID_DEVICE : ID_MAKER;
    endfunction

    function automatic logic [DATA_W-1:0] mix16(input logic [DATA_W-1:0] a);
        logic [DATA_W-1:0] p;
        p = a * MIX_K;
        return p;
    endfunction

endpackage

// File: rtl/rom_mode_decode.sv
module rom_mode_decode
    import rom_port_pkg::*;
(
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       wide,
    input  logic       id_mode,
    output port_mode_e mode
);
    always_comb begin
        if (ce_n)
            mode = PM_STANDBY;
        else if (oe_n)
            mode = PM_OUT_OFF;
        else if (id_mode)
            mode = wide ? PM_ID_WORD : PM_ID_BYTE;
        else
            mode = wide ? PM_WORD : PM_BYTE;
    end
endmodule

// File: rtl/rom_content.sv
module rom_content
    import rom_port_pkg::*;
#(
    parameter int                ADDR_W = 20,
    parameter logic [DATA_W-1:0] SEED   = 16'h5A3C
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);
    localparam int LOW_W = (ADDR_W < DATA_W) ? ADDR_W : DATA_W;
    localparam int FOLD_W = 4;

    logic [DATA_W-1:0] low_part;
    logic [FOLD_W-1:0] fold;

    always_comb begin
        low_part = '0;
        low_part[LOW_W-1:0] = addr[LOW_W-1:0];
    end

    generate
        if (ADDR_W > DATA_W) begin : g_fold
            always_comb begin
                fold = '0;
                for (int i = DATA_W; i < ADDR_W; i++)
                    fold[(i - DATA_W) % FOLD_W] = fold[(i - DATA_W) % FOLD_W] ^ addr[i];
            end
        end else begin : g_nofold
            assign fold = '0;
        end
    endgenerate

    assign word = mix16(low_part) ^ {(DATA_W / FOLD_W){fold}} ^ SEED;
endmodule

// File: rtl/rom_lane_select.sv
module rom_lane_select
    import rom_port_pkg::*;
(
    input  port_mode_e        mode,
    input  logic [DATA_W-1:0] word,
    input  logic              half_sel,
    input  logic              code_sel,
    output bus_t              bus
);
    logic [BYTE_W-1:0] half_byte;
    logic [BYTE_W-1:0] code;

    assign half_byte = half_sel ? word[2*BYTE_W-1:BYTE_W] : word[BYTE_W-1:0];
    assign code      = id_code(code_sel);
    assign bus.lp    = (mode == PM_STANDBY);

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            always_comb begin
                bus.data[k*BYTE_W +: BYTE_W] = '0;
                bus.en[k*BYTE_W +: BYTE_W]   = '0;
                unique case (mode)
                    PM_WORD: begin
                        bus.data[k*BYTE_W +: BYTE_W] = word[k*BYTE_W +: BYTE_W];
                        bus.en[k*BYTE_W +: BYTE_W]   = '1;
                    end
                    PM_ID_WORD: begin
                        bus.data[k*BYTE_W +: BYTE_W] = code;
                        bus.en[k*BYTE_W +: BYTE_W]   = '1;
                    end
                    PM_BYTE: if (k == 0) begin
                        bus.data[k*BYTE_W +: BYTE_W] = half_byte;
                        bus.en[k*BYTE_W +: BYTE_W]   = '1;
                    end
                    PM_ID_BYTE: if (k == 0) begin
                        bus.data[k*BYTE_W +: BYTE_W] = code;
                        bus.en[k*BYTE_W +: BYTE_W]   = '1;
                    end
                    default: ;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/dual_rom_port.sv
module dual_rom_port
    import rom_port_pkg::*;
#(
    parameter int                ADDR_W = 20,
    parameter logic [DATA_W-1:0] SEED   = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              a_m1,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              wide,
    input  logic              id_mode,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] dout_en,
    output logic              low_power
);
    port_mode_e        mode;
    logic [DATA_W-1:0] word;
    bus_t              bus_d;
    bus_t              bus_q;

    rom_mode_decode u_dec (
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .wide    (wide),
        .id_mode (id_mode),
        .mode    (mode)
    );

    rom_content #(.ADDR_W(ADDR_W), .SEED(SEED)) u_rom (
        .addr (addr),
        .word (word)
    );

    rom_lane_select u_sel (
        .mode     (mode),
        .word     (word),
        .half_sel (a_m1),
        .code_sel (addr[0]),
        .bus      (bus_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q.data <= '0;
            bus_q.en   <= '0;
            bus_q.lp   <= 1'b1;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign dout      = bus_q.data;
    assign dout_en   = bus_q.en;
    assign low_power = bus_q.lp;
endmodule

// File: rtl/rom_port_chk.sv
module rom_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        addr0,
    input logic        ce_n,
    input logic        oe_n,
    input logic        wide,
    input logic        id_mode,
    input logic [15:0] dout,
    input logic [15:0] dout_en,
    input logic        low_power
);
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (dout_en == 16'h0000) && low_power);                       // R6

    AST_OUT_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && oe_n) |=> (dout_en == 16'h0000) && !low_power);           // R5

    AST_BYTE_LANES: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && !wide) |=> (dout_en == 16'h00FF));               // R4

    AST_WORD_LANES: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && wide) |=> (dout_en == 16'hFFFF));                // R1

    AST_ID_CODE: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && id_mode) |=>
            (dout[7:0] == ($past(addr0) ? 8'hB1 : 8'h20)));                 // R7

    AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dout & ~dout_en) == 16'h0000);                                     // R10

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (dout_en == 16'h0000) && low_power);                        // R9
endmodule

bind dual_rom_port rom_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr0     (addr[0]),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .wide      (wide),
    .id_mode   (id_mode),
    .dout      (dout),
    .dout_en   (dout_en),
    .low_power (low_power)
);

// File: tb/dual_rom_port_test.sv
module dual_rom_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] addr = '0;
    logic        a_m1 = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        wide = 1'b1;
    logic        id_mode = 1'b0;
    logic [15:0] dout;
    logic [15:0] dout_en;
    logic        low_power;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dual_rom_port uut (
        .clk(clk), .rst(rst), .addr(addr), .a_m1(a_m1), .ce_n(ce_n),
        .oe_n(oe_n), .wide(wide), .id_mode(id_mode),
        .dout(dout), .dout_en(dout_en), .low_power(low_power)
    );

    function automatic logic [15:0] w_of(input logic [19:0] a);
        logic [15:0] p;
        p = a[15:0] * 16'h9E37;
        return p ^ {4{a[19:16]}} ^ 16'h5A3C;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive at the falling edge, sample 1 ns after the next rising edge
    task automatic cyc(input logic [19:0] a, input logic m1, input logic c,
                       input logic o, input logic w, input logic id);
        @(negedge clk);
        addr = a; a_m1 = m1; ce_n = c; oe_n = o; wide = w; id_mode = id;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [19:0] a;
        logic [15:0] w;
        // R9 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset", {dout_en, dout}, 32'h0);
        chk("R9 reset lp", {31'h0, low_power}, 32'h1);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R9 after release", {dout_en, dout, 15'h0, low_power}, {32'h0, 16'h1} >> 0);

        // R1 R2 R3 R4 R11 sweep
        for (int i = 0; i < 258; i++) begin
            if (i == 256) a = 20'h00000;
            else if (i == 257) a = 20'hFFFFF;
            else a = 20'(i * 4099 + i * 65536 * 3);
            w = w_of(a);
            cyc(a, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            chk("R1 word", {dout_en, dout}, {16'hFFFF, w});
            cyc(a, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
            chk("R11 a_m1 in word", {16'h0, dout}, {16'h0, w});
            cyc(a, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R2 byte low", {dout_en, dout}, {16'h00FF, 8'h00, w[7:0]});
            cyc(a, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
            chk("R3 byte high", {16'h0, dout}, {16'h0, 8'h00, w[15:8]});
            chk("R4 byte lanes", {dout_en, 8'h0, dout[15:8]}, {16'h00FF, 16'h0});
        end

        // R7 identification codes
        for (int j = 0; j < 16; j++) begin
            a = {j[3:0], 15'h5A5A, j[0]};
            cyc(a, j[1], 1'b0, 1'b0, 1'b1, 1'b1);
            chk("R7 id word", {dout_en, dout},
                {16'hFFFF, j[0] ? 16'hB1B1 : 16'h2020});
            cyc(a, j[1], 1'b0, 1'b0, 1'b0, 1'b1);
            chk("R7 id byte", {dout_en, dout},
                {16'h00FF, 8'h00, j[0] ? 8'hB1 : 8'h20});
        end

        // R5 R6 R10 all other-control combinations
        for (int k = 0; k < 8; k++) begin
            cyc(20'hABCDE, k[0], 1'b0, 1'b1, k[1], k[2]);
            chk("R5 out off", {dout_en, dout}, 32'h0);
            chk("R5 lp", {31'h0, low_power}, 32'h0);
            cyc(20'h12345, k[0], 1'b1, k[1], k[2], k[0]);
            chk("R6 standby", {dout_en, dout}, 32'h0);
            chk("R6 lp", {31'h0, low_power}, 32'h1);
        end
        chk("R10 idle lanes", {16'h0, dout & ~dout_en}, 32'h0);

        // R8 mid-cycle change has no effect until the next edge
        cyc(20'h0F0F0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        addr = 20'h33333;
        wide = 1'b0;
        #1;
        chk("R8 hold", {dout_en, dout}, {16'hFFFF, w_of(20'h0F0F0)});
        @(posedge clk);
        #1;
        chk("R8 next edge", {dout_en, dout}, {16'h00FF, 8'h00, w_of(20'h33333)[7:0]});

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule